// File: doc/BRIEF.md
# I2C Master Byte Engine with Acknowledge Wait

This block moves one byte over an I2C bus as the master. It generates SCL from a divided system clock and shifts eight data bits, most significant bit first, either out onto SDA (transmit) or in from SDA (receive). It then issues a ninth clock for the acknowledge bit. Both bus lines are open-drain: the block only pulls a line low or lets it go. A transfer begins with a one-cycle start strobe. Generating START and STOP conditions, arbitration, slave mode and slave clock stretching are handled outside this block.

Software sees an interrupt flag that is set on the rising edge of the acknowledge clock, and a 3-bit bit counter. When the wait option is on, the engine holds SCL low after the eighth clock falls and issues the acknowledge clock only after software pulses the flag-clear strobe during that hold. A clear pulse that lands in the late window, between the seventh and eighth falling edges, is discarded. It neither clears the flag nor is stored, so it cannot cut the wait short. When the wait option is off, the acknowledge clock follows the eighth clock with no gap.

Top module: `i2c_wait_master`

## Requirements
- R1: While reset is held and after it is released, the block releases SCL and SDA (`scl_oe`=0, `sda_oe`=0) and drives `flag`=0, `bit_cnt`=0 and `busy`=0.
- R2: Each transfer, from `start_byte` until `busy` falls, produces exactly nine SCL rising edges. SCL stays driven low once the byte has ended.
- R3: `bit_cnt` changes only on SCL falling edges of clocks 1 to 8, and each change decrements it by one modulo 8. Sampled at the rising edge of clock k, it reads 0 for k=1, 9-k for k=2..8, and 0 for k=9.
- R4: With `rx_mode`=0, bit 7-(k-1) of `tx_byte` is on SDA while SCL is high in clock k (k=1..8), and SDA is released during clock 9. `ack_bit` returns the SDA level seen in clock 9, where 0 means acknowledged.
- R5: With `rx_mode`=1, `rx_byte` holds the eight SDA levels sampled in clocks 1 to 8, most significant bit first. In clock 9 the block pulls SDA low when `ack_drive`=1 and releases it when `ack_drive`=0.
- R6: `flag` becomes 1 in the same cycle that SCL is released for clock 9.
- R7: A `flag_clr` pulse clears `flag` on the next cycle when it arrives outside the late window and outside a wait.
- R8: A `flag_clr` pulse that arrives while `busy`=1 and `bit_cnt`=1 (between the 7th and 8th falls) is ignored. `flag` keeps its value, and the pulse is not remembered.
- R9: With `wait_en`=1 captured at start, SCL stays low after the 8th fall until a `flag_clr` pulse arrives during the hold. Clock 9 then goes high on the next cycle, and only once.
- R10: With `wait_en`=0 captured at start, the low phase before clock 9 lasts exactly `HALF_CYC` cycles.
- R11: `sda_oe` changes only in a cycle in which SCL was driven low in both that cycle and the one before.
- R12: Every SCL high phase, and every low phase from clock 2 to clock 8, lasts `HALF_CYC` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_byte | input | 1 | One-cycle strobe that starts a byte when idle |
| rx_mode | input | 1 | 1 = receive, 0 = transmit; captured at start |
| wait_en | input | 1 | 1 = hold SCL low before the acknowledge clock; captured at start |
| ack_drive | input | 1 | In receive, 1 = pull SDA low in clock 9; captured at start |
| tx_byte | input | 8 | Byte to transmit; captured at start |
| flag_clr | input | 1 | One-cycle strobe that clears the flag or ends a wait |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 = pull SCL low, 0 = release |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| flag | output | 1 | Interrupt flag, set at the acknowledge clock |
| bit_cnt | output | 3 | Bit counter |
| busy | output | 1 | A byte transfer is in progress |
| ack_bit | output | 1 | SDA level sampled in clock 9 |
| rx_byte | output | 8 | Received byte |

## Verification
The hardest situation to reach is a flag clear that lands in the late window, between the seventh and eighth falling edges, while the flag is still set from the previous byte, on a byte that also has the wait enabled. The stimulus leaves the flag uncleared through one byte. On the next byte it polls `bit_cnt` at the ports until it reads 1 and pulses `flag_clr` at that point. It then waits for the counter to reach 0 and keeps SCL low for several more half-periods, checking that no ninth rising edge has appeared, before it sends the clear that releases the hold. Random bytes with mixed modes, data, acknowledge values and clear points fill in around these directed cases.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned ACK_IDX = BYTE_W + 1;
    localparam int unsigned IDX_W   = $clog2(ACK_IDX + 1);
    localparam int unsigned BCNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOW,
        SQ_HIGH,
        SQ_WAIT,
        SQ_TAIL
    } sq_state_t;

    typedef struct packed {
        logic rx_dir;
        logic wait_on;
        logic ack_drv;
    } byte_cfg_t;

    function automatic logic [BCNT_W-1:0] bc_after_fall(input logic [BCNT_W-1:0] bc);
        return bc - 1'b1;
    endfunction

    // Level to pull onto SDA during the low phase of clock number idx
    function automatic logic sda_pull(input byte_cfg_t cfg, input logic [IDX_W-1:0] idx,
                                      input logic tx_bit);
        if (idx < IDX_W'(ACK_IDX)) begin
            return cfg.rx_dir ? 1'b0 : ~tx_bit;
        end
        return cfg.rx_dir ? cfg.ack_drv : 1'b0;
    endfunction

endpackage

// File: rtl/i2cw_phase_timer.sv
module i2cw_phase_timer #(
    parameter int unsigned HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic done
);
    localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cw_shifter.sv
module i2cw_shifter import i2cw_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              shift,
    input  logic              capture,
    input  logic              sda_in,
    output logic              tx_bit,
    output logic [BYTE_W-1:0] rx_byte
);
    logic [BYTE_W-1:0] tx_sh;

    assign tx_bit = tx_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            rx_byte <= '0;
        end else begin
            if (load) begin
                tx_sh <= load_byte;
            end else if (shift) begin
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
            end
            if (load) begin
                rx_byte <= '0;
            end else if (capture) begin
                rx_byte <= {rx_byte[BYTE_W-2:0], sda_in};
            end
        end
    end
endmodule

// File: rtl/i2cw_seq.sv
module i2cw_seq import i2cw_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_req,
    input  byte_cfg_t         cfg_in,
    input  logic              flag_clr,
    input  logic              timer_done,
    input  logic              sda_in,
    output sq_state_t         state,
    output byte_cfg_t         cfg,
    output logic [IDX_W-1:0]  clk_idx,
    output logic [BCNT_W-1:0] bit_cnt,
    output logic              flag,
    output logic              ack_bit,
    output logic              scl_drive,
    output logic              timer_restart,
    output logic              timer_run,
    output logic              load,
    output logic              shift,
    output logic              capture
);
    sq_state_t nxt;
    logic      owned;
    logic      at_ack;
    logic      ack_rise;
    logic      clr_ok;
    logic      fall_data;

    assign at_ack = (clk_idx == IDX_W'(ACK_IDX));

    always_comb begin
        nxt           = state;
        timer_restart = 1'b0;
        load          = 1'b0;
        shift         = 1'b0;
        capture       = 1'b0;
        unique case (state)
            SQ_IDLE: begin
                if (start_req) begin
                    nxt           = SQ_LOW;
                    timer_restart = 1'b1;
                    load          = 1'b1;
                end
            end
            SQ_LOW: begin
                if (timer_done) begin
                    timer_restart = 1'b1;
                    nxt           = (at_ack && cfg.wait_on) ? SQ_WAIT : SQ_HIGH;
                end
            end
            SQ_WAIT: begin
                if (flag_clr) begin
                    timer_restart = 1'b1;
                    nxt           = SQ_HIGH;
                end
            end
            SQ_HIGH: begin
                if (timer_done) begin
                    timer_restart = 1'b1;
                    capture       = !at_ack;
                    if (at_ack) begin
                        nxt = SQ_TAIL;
                    end else begin
                        nxt   = SQ_LOW;
                        shift = 1'b1;
                    end
                end
            end
            SQ_TAIL: begin
                if (timer_done) begin
                    timer_restart = 1'b1;
                    nxt           = SQ_IDLE;
                end
            end
            default: nxt = SQ_IDLE;
        endcase
    end

    assign timer_run = (state == SQ_LOW) || (state == SQ_HIGH) || (state == SQ_TAIL);
    assign scl_drive = (state == SQ_LOW) || (state == SQ_WAIT) || (state == SQ_TAIL) ||
                       ((state == SQ_IDLE) && owned);
    assign ack_rise  = at_ack && (nxt == SQ_HIGH) && (state != SQ_HIGH);
    assign fall_data = (state == SQ_HIGH) && timer_done && !at_ack;
    // a clear arriving between the 7th and 8th falls is dropped outright
    assign clr_ok    = !((state != SQ_IDLE) && (bit_cnt == BCNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            cfg     <= '0;
            clk_idx <= '0;
            bit_cnt <= '0;
            flag    <= 1'b0;
            ack_bit <= 1'b0;
            owned   <= 1'b0;
        end else begin
            state <= nxt;
            if (load) begin
                cfg     <= cfg_in;
                clk_idx <= IDX_W'(1);
                owned   <= 1'b1;
            end else if (fall_data) begin
                clk_idx <= clk_idx + 1'b1;
                bit_cnt <= bc_after_fall(bit_cnt);
            end
            if ((state == SQ_HIGH) && timer_done && at_ack) begin
                ack_bit <= sda_in;
            end
            if (ack_rise) begin
                flag <= 1'b1;
            end else if (flag_clr && clr_ok) begin
                flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2c_wait_master.sv
module i2c_wait_master import i2cw_pkg::*; #(
    parameter int unsigned HALF_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_byte,
    input  logic              rx_mode,
    input  logic              wait_en,
    input  logic              ack_drive,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              flag_clr,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              flag,
    output logic [BCNT_W-1:0] bit_cnt,
    output logic              busy,
    output logic              ack_bit,
    output logic [BYTE_W-1:0] rx_byte
);
    sq_state_t        state;
    byte_cfg_t        cfg_in;
    byte_cfg_t        cfg;
    logic [IDX_W-1:0] clk_idx;
    logic             timer_restart;
    logic             timer_run;
    logic             timer_done;
    logic             load;
    logic             shift;
    logic             capture;
    logic             tx_bit;
    logic             in_wait;
    logic             ack_clk;

    assign cfg_in  = '{rx_dir: rx_mode, wait_on: wait_en, ack_drv: ack_drive};
    assign busy    = (state != SQ_IDLE);
    assign in_wait = (state == SQ_WAIT);
    assign ack_clk = (clk_idx == IDX_W'(ACK_IDX));

    i2cw_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (timer_restart),
        .run     (timer_run),
        .done    (timer_done)
    );

    i2cw_seq u_seq (
        .clk           (clk),
        .rst           (rst),
        .start_req     (start_byte),
        .cfg_in        (cfg_in),
        .flag_clr      (flag_clr),
        .timer_done    (timer_done),
        .sda_in        (sda_in),
        .state         (state),
        .cfg           (cfg),
        .clk_idx       (clk_idx),
        .bit_cnt       (bit_cnt),
        .flag          (flag),
        .ack_bit       (ack_bit),
        .scl_drive     (scl_oe),
        .timer_restart (timer_restart),
        .timer_run     (timer_run),
        .load          (load),
        .shift         (shift),
        .capture       (capture)
    );

    i2cw_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_byte (tx_byte),
        .shift     (shift),
        .capture   (capture),
        .sda_in    (sda_in),
        .tx_bit    (tx_bit),
        .rx_byte   (rx_byte)
    );

    // SDA is updated one cycle into a low phase and never in its last cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            sda_oe <= 1'b0;
        end else if (((state == SQ_LOW) || (state == SQ_WAIT)) && !timer_done && !flag_clr) begin
            sda_oe <= sda_pull(cfg, clk_idx, tx_bit);
        end else if ((state == SQ_LOW) && !timer_done) begin
            sda_oe <= sda_pull(cfg, clk_idx, tx_bit);
        end else if (state == SQ_TAIL) begin
            sda_oe <= 1'b0;
        end
    end
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker (
    input logic       clk,
    input logic       rst,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       flag,
    input logic       flag_clr,
    input logic [2:0] bit_cnt,
    input logic       busy,
    input logic       in_wait,
    input logic       ack_clk
);
    logic       scl_q;
    logic [3:0] rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b0;
            rises <= '0;
        end else begin
            scl_q <= scl_oe;
            if (!busy) begin
                rises <= '0;
            end else if (scl_q && !scl_oe) begin
                rises <= rises + 1'b1;
            end
        end
    end

    AST_RESET_RELEASE: assert property (@(posedge clk) rst |=> (!scl_oe && !sda_oe && !flag && !busy && bit_cnt == 3'd0)); // R1
    AST_NINE_CLOCKS: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> (rises == 4'd9)); // R2
    AST_NO_EXTRA_CLOCK: assert property (@(posedge clk) disable iff (rst) rises <= 4'd9); // R2
    AST_BITCNT_DOWN: assert property (@(posedge clk) disable iff (rst) !$stable(bit_cnt) |-> (bit_cnt == $past(bit_cnt) - 3'd1)); // R3
    AST_BITCNT_ON_FALL: assert property (@(posedge clk) disable iff (rst) !$stable(bit_cnt) |-> (scl_oe && !$past(scl_oe))); // R3
    AST_FLAG_AT_ACK: assert property (@(posedge clk) disable iff (rst) ($fell(scl_oe) && ack_clk) |-> flag); // R6
    AST_LATE_CLEAR_DROPPED: assert property (@(posedge clk) disable iff (rst) (busy && bit_cnt == 3'd1 && flag_clr && flag) |=> flag); // R8
    AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (rst) in_wait |-> scl_oe); // R9
    AST_WAIT_EXIT_ON_CLEAR: assert property (@(posedge clk) disable iff (rst) $fell(in_wait) |-> $past(flag_clr)); // R9
    AST_SDA_WHILE_LOW: assert property (@(posedge clk) disable iff (rst) !$stable(sda_oe) |-> (scl_oe && $past(scl_oe))); // R11
endmodule

bind i2c_wait_master i2cw_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .flag     (flag),
    .flag_clr (flag_clr),
    .bit_cnt  (bit_cnt),
    .busy     (busy),
    .in_wait  (in_wait),
    .ack_clk  (ack_clk)
);

// File: tb/i2c_wait_master_tb.sv
module i2c_wait_master_tb;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_byte = 1'b0;
    logic       rx_mode = 1'b0;
    logic       wait_en = 1'b0;
    logic       ack_drive = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       flag_clr = 1'b0;
    logic       sda_in;
    logic       scl_oe, sda_oe, flag, busy, ack_bit;
    logic [2:0] bit_cnt;
    logic [7:0] rx_byte;
    logic       sl_pull;
    wire        sda_line = ~(sda_oe | sl_pull);

    assign sda_in = sda_line;

    always #5 clk = ~clk;

    i2c_wait_master #(.HALF_CYC(HALF)) u_dut (
        .clk(clk), .rst(rst), .start_byte(start_byte), .rx_mode(rx_mode),
        .wait_en(wait_en), .ack_drive(ack_drive), .tx_byte(tx_byte),
        .flag_clr(flag_clr), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .flag(flag), .bit_cnt(bit_cnt), .busy(busy), .ack_bit(ack_bit),
        .rx_byte(rx_byte)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // slave model settings, written by the stimulus only
    bit       cur_rx = 1'b0;
    bit [7:0] cur_sb = 8'h00;
    bit       cur_sack = 1'b0;

    // bus monitor state, written by the monitor only
    int       rc, low_len, high_len, sda_viol;
    logic     scl_prev, busy_prev, sda_prev;
    logic [7:0] cap;
    logic     cap_ack, flag9;
    int       bc_at [1:9];
    int       low_at [1:9];
    int       high_at [1:9];

    function automatic int exp_bc(input int k);
        return (k == 1) ? 0 : ((9 - k) % 8);
    endfunction

    function automatic logic slave_pull(input int r);
        if (cur_rx) return (r < 8) ? !cur_sb[7 - r] : 1'b0;
        return (r == 8) ? cur_sack : 1'b0;
    endfunction

    always @(negedge clk) begin
        logic scl_now;
        scl_now = !scl_oe;
        if (rst) begin
            rc = 0; low_len = 0; high_len = 0; sda_viol = 0;
            scl_prev = 1'b1; busy_prev = 1'b0; sda_prev = 1'b0;
            sl_pull = 1'b0; cap = 8'h00; cap_ack = 1'b0; flag9 = 1'b0;
        end else begin
            if (busy && !busy_prev) begin
                rc = 0;
                sda_viol = 0;
            end
            if ((sda_oe != sda_prev) && (scl_now || scl_prev)) sda_viol++;
            if (!scl_now) low_len = scl_prev ? 1 : low_len + 1;
            else high_len = scl_prev ? high_len + 1 : 1;
            if (scl_now && !scl_prev && busy) begin
                rc++;
                if (rc <= 9) begin
                    bc_at[rc] = bit_cnt;
                    low_at[rc] = low_len;
                end
                if (rc <= 8) cap = {cap[6:0], sda_line};
                else if (rc == 9) begin
                    cap_ack = sda_line;
                    flag9 = flag;
                end
            end
            if (!scl_now && scl_prev && busy && rc >= 1 && rc <= 9) high_at[rc] = high_len;
            if (!scl_now) sl_pull = slave_pull(rc);
            sda_prev = sda_oe;
            scl_prev = scl_now;
            busy_prev = busy;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    // clr_mode: 0 none, 1 clear at bit_cnt 3, 2 clear in the late window (bit_cnt 1)
    task automatic run_byte(input logic [7:0] txb, input bit rxm, input bit wen, input bit ackd,
                            input logic [7:0] sb, input bit sack, input int clr_mode);
        logic fb;
        step();
        cur_rx = rxm; cur_sb = sb; cur_sack = sack;
        tx_byte = txb; rx_mode = rxm; wait_en = wen; ack_drive = ackd;
        start_byte = 1'b1;
        step();
        start_byte = 1'b0;
        if (clr_mode == 1) begin
            while (bit_cnt != 3'd3) step();
            pulse_clr();
            step();
            chk(flag == 1'b0, "R7", "flag after clear at bit_cnt 3", flag, 0);
        end else if (clr_mode == 2) begin
            while (!(busy && bit_cnt == 3'd1)) step();
            fb = flag;
            pulse_clr();
            step();
            chk(flag == fb, "R8", "flag after late-window clear", flag, fb);
        end
        if (wen) begin
            while (!(rc == 8 && bit_cnt == 3'd0)) step();
            repeat (3 * HALF) step();
            chk(rc == 8, "R9", "rises while waiting", rc, 8);
            chk(scl_oe == 1'b1, "R9", "SCL held low in wait", scl_oe, 1);
            pulse_clr();
        end
        while (busy) step();
        step();
        chk(rc == 9, "R2", "SCL rises per byte", rc, 9);
        chk(scl_oe == 1'b1, "R2", "SCL low after byte", scl_oe, 1);
        chk(sda_viol == 0, "R11", "SDA changes while SCL high", sda_viol, 0);
        chk(flag9 == 1'b1, "R6", "flag at 9th rise", flag9, 1);
        for (int k = 1; k <= 9; k++) begin
            chk(bc_at[k] == exp_bc(k), "R3", $sformatf("bit_cnt at rise %0d", k), bc_at[k], exp_bc(k));
            chk(high_at[k] == HALF, "R12", $sformatf("high length clock %0d", k), high_at[k], HALF);
        end
        for (int k = 2; k <= 8; k++) begin
            chk(low_at[k] == HALF, "R12", $sformatf("low length clock %0d", k), low_at[k], HALF);
        end
        if (wen) chk(low_at[9] > 3 * HALF, "R9", "low length before ack clock", low_at[9], 3 * HALF + 1);
        else     chk(low_at[9] == HALF, "R10", "low length before ack clock", low_at[9], HALF);
        if (rxm) begin
            chk(rx_byte == sb, "R5", "received byte", rx_byte, sb);
            chk(cap_ack == !ackd, "R5", "SDA level in ack clock", cap_ack, !ackd);
        end else begin
            chk(cap == txb, "R4", "bits seen on SDA", cap, txb);
            chk(cap_ack == !sack, "R4", "SDA level in ack clock", cap_ack, !sack);
            chk(ack_bit == !sack, "R4", "ack_bit", ack_bit, !sack);
        end
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (4) step();
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "lines released in reset", {scl_oe, sda_oe}, 0);
        rst = 1'b0;
        step();
        chk(scl_oe == 1'b0, "R1", "scl_oe after reset", scl_oe, 0);
        chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
        chk(flag == 1'b0, "R1", "flag after reset", flag, 0);
        chk(bit_cnt == 3'd0, "R1", "bit_cnt after reset", bit_cnt, 0);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);

        run_byte(8'hA5, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 0);
        run_byte(8'h3C, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 2);
        run_byte(8'h00, 1'b1, 1'b1, 1'b1, 8'hC3, 1'b0, 1);
        run_byte(8'h00, 1'b1, 1'b0, 1'b0, 8'h5A, 1'b0, 2);
        run_byte(8'hFF, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 0);
        run_byte(8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1);
        run_byte(8'h00, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b0, 0);

        for (int i = 0; i < 20; i++) begin
            run_byte(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     8'($urandom), 1'($urandom), int'($urandom % 3));
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule